// File: doc/BRIEF.md
# Translated-Pointer Host Data Port

This block gives a host word-at-a-time access to a small variable memory through one data register. The host never presents a memory address with each access. It first asks a built-in translator to look up an address. It waits until the translator reports that it is idle again, then commits the result. The commit loads an internal pointer, a count of the words left in the matched region, and a flag that says whether that region may be written.

After the commit, each read or write strobe moves the pointer forward by one word. Reads pass through one pipeline stage, so the first read after a commit returns whatever the pipeline held before. Writes land at once, but only while the pointer sits inside a writable region that still has words left. A write outside those limits is dropped and raises a sticky error flag.

Top module: `hdc_conduit`

## Requirements
- R1: After synchronous reset, `xlat_done` is 1 and `remain_len`, `writable`, `wr_err` and `rd_data` are all 0.
- R2: A `xlat_req` sampled while `xlat_done` is 1 drives `xlat_done` to 0 on the next cycle. `xlat_done` returns to 1 exactly XLAT_LAT (4) clock edges after the request edge. A request made while `xlat_done` is 0 is ignored.
- R3: The translator holds 8 regions. Region i covers the words from i*8 up to, but not including, i*8+L, where L = 2+2*(i mod 3). Region i is writable when i is odd. A matched address a gives a remaining length of i*8+L-a.
- R4: When no region matches the address, the result is a remaining length of 0 with `writable` at 0. The pointer is still loaded with the requested address. `writable` is never 1 while `remain_len` is 0.
- R5: A `commit` while `xlat_done` is 1 loads the pointer, the length and the writable flag from the last finished translation, and clears `wr_err`. A `commit` while `xlat_done` is 0 changes nothing.
- R6: The memory word at address a resets to (a*37+5) mod 2^16, and the read pipeline register resets to 0. Each read strobe returns, in `rd_data` on the next cycle, the word fetched by the previous read strobe. The read then fetches the word at the pointer. So the first read after a commit is a discard read, and the second read returns the word at the committed address.
- R7: Every read or write strobe moves the pointer on by one word, wrapping modulo 64. `remain_len` drops by one per strobe and stops at 0.
- R8: A write with `writable` at 1 stores `wr_data` at the pointer in the same cycle, with no pipeline delay.
- R9: A write made while `writable` is 0, whether the region is read-only or its length is used up, leaves the memory unchanged and sets `wr_err`. `wr_err` stays set until the next accepted commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xlat_req | input | 1 | Start a translation of `xlat_addr` |
| xlat_addr | input | 6 | Address to translate |
| xlat_done | output | 1 | Translator idle, result available |
| commit | input | 1 | Load pointer, length and writable flag from the translation |
| rd_strobe | input | 1 | Read one word through the data register |
| wr_strobe | input | 1 | Write one word through the data register |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data, one pipeline stage behind |
| remain_len | output | 7 | Words left in the current region, 0 = invalid pointer |
| writable | output | 1 | Pointer lies in a writable region with words left |
| wr_err | output | 1 | Sticky flag for a dropped write |

## Verification
The bench uses the package defaults: a 64-word memory, 8 regions with a stride of 8, and a 4-cycle lookup. At these sizes every memory address can be translated, committed, written once and read back. That covers every region boundary, every gap between regions, and both read-only and writable regions. The small memory also puts the pointer wrap from word 63 to word 0 and the exhaustion of a 4-word region within a few strobes. Dedicated sequences check commits and requests made while the translator is busy.

// File: rtl/hdc_pkg.sv
package hdc_pkg;

    localparam int DATA_W        = 16;
    localparam int ADDR_W        = 6;
    localparam int MEM_WORDS     = 1 << ADDR_W;
    localparam int N_REGIONS     = 8;
    localparam int REGION_STRIDE = MEM_WORDS / N_REGIONS;
    localparam int LEN_W         = ADDR_W + 1;
    localparam int XLAT_LAT      = 4;
    localparam int CNT_W         = $clog2(XLAT_LAT + 1);

    typedef logic [ADDR_W-1:0] waddr_t;
    typedef logic [DATA_W-1:0] word_t;
    typedef logic [LEN_W-1:0]  len_t;

    // Result of one translation: pointer, words left, write permission
    typedef struct packed {
        waddr_t ptr;
        len_t   len;
        logic   wr;
    } xlat_res_t;

    // Data-port action selected in a cycle
    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_READ,
        ACC_WRITE,
        ACC_COMMIT
    } acc_e;

    function automatic len_t region_len(int i);
        return len_t'(2 + 2 * (i % 3));
    endfunction

    function automatic logic region_wr(int i);
        return (i % 2) == 1;
    endfunction

    function automatic word_t init_word(int a);
        return word_t'(a * 37 + 5);
    endfunction

endpackage

// File: rtl/hdc_xlat.sv
module hdc_xlat
    import hdc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      req,
    input  waddr_t    addr,
    output logic      done,
    output xlat_res_t res
);

    waddr_t    tbl_base [N_REGIONS];
    len_t      tbl_len  [N_REGIONS];
    logic      tbl_wr   [N_REGIONS];

    for (genvar g = 0; g < N_REGIONS; g++) begin : g_tbl
        assign tbl_base[g] = waddr_t'(g * REGION_STRIDE);
        assign tbl_len[g]  = region_len(g);
        assign tbl_wr[g]   = region_wr(g);
    end

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;
    waddr_t           key_q;
    xlat_res_t        res_q;
    xlat_res_t        look;
    len_t             off;

    always_comb begin
        look     = '0;
        look.ptr = key_q;
        off      = '0;
        for (int i = 0; i < N_REGIONS; i++) begin
            off = len_t'(key_q) - len_t'(tbl_base[i]);
            if (key_q >= tbl_base[i] && off < tbl_len[i]) begin
                look.len = tbl_len[i] - off;
                look.wr  = tbl_wr[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            key_q  <= '0;
            res_q  <= '0;
        end else if (req && !busy_q) begin
            busy_q <= 1'b1;
            key_q  <= addr;
            cnt_q  <= CNT_W'(XLAT_LAT - 1);
        end else if (busy_q) begin
            if (cnt_q == '0) begin
                busy_q <= 1'b0;
                res_q  <= look;
            end else begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

    assign done = !busy_q;
    assign res  = res_q;

    // R2: an accepted request makes the translator busy on the next cycle
    p_req_starts_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (req && done) |=> !done);

    // R2: an idle translator keeps its result until a new request arrives
    p_idle_result_stable_r2: assert property (@(posedge clk) disable iff (rst)
        (done && !req) |=> (done && $stable(res)));

endmodule

// File: rtl/hdc_ptr.sv
module hdc_ptr
    import hdc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  acc_e      acc,
    input  xlat_res_t res,
    output waddr_t    ptr,
    output len_t      remain,
    output logic      writable,
    output logic      err,
    output logic      wr_ok,
    output logic      rd_ok
);

    waddr_t ptr_q;
    len_t   rem_q;
    logic   wf_q;
    logic   err_q;

    assign writable = wf_q && (rem_q != '0);
    assign wr_ok    = (acc == ACC_WRITE) && writable;
    assign rd_ok    = (acc == ACC_READ);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
            rem_q <= '0;
            wf_q  <= 1'b0;
            err_q <= 1'b0;
        end else begin
            unique case (acc)
                ACC_COMMIT: begin
                    ptr_q <= res.ptr;
                    rem_q <= res.len;
                    wf_q  <= res.wr;
                    err_q <= 1'b0;
                end
                ACC_READ, ACC_WRITE: begin
                    ptr_q <= ptr_q + waddr_t'(1);
                    if (rem_q != '0) rem_q <= rem_q - len_t'(1);
                    if (acc == ACC_WRITE && !writable) err_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign ptr    = ptr_q;
    assign remain = rem_q;
    assign err    = err_q;

    // R7: each access moves the pointer forward by one word
    p_ptr_step_r7: assert property (@(posedge clk) disable iff (rst)
        (acc == ACC_READ || acc == ACC_WRITE) |=> ptr_q == $past(ptr_q) + waddr_t'(1));

    // R7: the remaining length drops by one per access while nonzero
    p_remain_dec_r7: assert property (@(posedge clk) disable iff (rst)
        ((acc == ACC_READ || acc == ACC_WRITE) && rem_q != '0) |=> rem_q == $past(rem_q) - len_t'(1));

    // R9: the error flag is sticky until a commit
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (err_q && acc != ACC_COMMIT) |=> err_q);

endmodule

// File: rtl/hdc_store.sv
module hdc_store
    import hdc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   rd_en,
    input  logic   wr_en,
    input  waddr_t addr,
    input  word_t  wdata,
    output word_t  rdata
);

    word_t mem [MEM_WORDS];
    word_t pipe_q;
    word_t rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int a = 0; a < MEM_WORDS; a++) mem[a] <= init_word(a);
            pipe_q  <= '0;
            rdata_q <= '0;
        end else begin
            if (wr_en) mem[addr] <= wdata;
            if (rd_en) begin
                rdata_q <= pipe_q;
                pipe_q  <= mem[addr];
            end
        end
    end

    assign rdata = rdata_q;

    // R6: the data register changes only on a read
    p_rdata_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata_q));

endmodule

// File: rtl/hdc_conduit.sv
module hdc_conduit
    import hdc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              xlat_req,
    input  logic [ADDR_W-1:0] xlat_addr,
    output logic              xlat_done,
    input  logic              commit,
    input  logic              rd_strobe,
    input  logic              wr_strobe,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [LEN_W-1:0]  remain_len,
    output logic              writable,
    output logic              wr_err
);

    xlat_res_t res;
    acc_e      acc;
    waddr_t    ptr;
    logic      wr_ok;
    logic      rd_ok;

    hdc_xlat u_xlat (
        .clk  (clk),
        .rst  (rst),
        .req  (xlat_req),
        .addr (xlat_addr),
        .done (xlat_done),
        .res  (res)
    );

    // commit (when idle) over write over read
    always_comb begin
        if (commit && xlat_done) acc = ACC_COMMIT;
        else if (wr_strobe)      acc = ACC_WRITE;
        else if (rd_strobe)      acc = ACC_READ;
        else                     acc = ACC_NONE;
    end

    hdc_ptr u_ptr (
        .clk      (clk),
        .rst      (rst),
        .acc      (acc),
        .res      (res),
        .ptr      (ptr),
        .remain   (remain_len),
        .writable (writable),
        .err      (wr_err),
        .wr_ok    (wr_ok),
        .rd_ok    (rd_ok)
    );

    hdc_store u_store (
        .clk   (clk),
        .rst   (rst),
        .rd_en (rd_ok),
        .wr_en (wr_ok),
        .addr  (ptr),
        .wdata (wr_data),
        .rdata (rd_data)
    );

    // R4: a zero length never allows writes
    p_zero_len_locked_r4: assert property (@(posedge clk) disable iff (rst)
        (remain_len == '0) |-> !writable);

    // R9: a write without permission raises the error flag
    p_bad_write_flags_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_strobe && !(commit && xlat_done) && !writable) |=> wr_err);

    // R5: an accepted commit clears the error flag
    p_commit_clears_err_r5: assert property (@(posedge clk) disable iff (rst)
        (commit && xlat_done) |=> !wr_err);

endmodule

// File: tb/sim_hdc_conduit.sv
module sim_hdc_conduit;
    import hdc_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              xlat_req = 1'b0;
    logic [ADDR_W-1:0] xlat_addr = '0;
    logic              xlat_done;
    logic              commit = 1'b0;
    logic              rd_strobe = 1'b0;
    logic              wr_strobe = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [DATA_W-1:0] rd_data;
    logic [LEN_W-1:0]  remain_len;
    logic              writable;
    logic              wr_err;

    always #10 clk = ~clk;

    hdc_conduit u0 (
        .clk(clk), .rst(rst), .xlat_req(xlat_req), .xlat_addr(xlat_addr),
        .xlat_done(xlat_done), .commit(commit), .rd_strobe(rd_strobe),
        .wr_strobe(wr_strobe), .wr_data(wr_data), .rd_data(rd_data),
        .remain_len(remain_len), .writable(writable), .wr_err(wr_err)
    );

    int n_chk = 0;
    int n_bad = 0;

    // bench model
    int bmem [MEM_WORDS];
    int bpipe = 0, bptr = 0, brem = 0, bwf = 0, berr = 0;
    int nptr = 0, nrem = 0, nwf = 0;

    task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    function automatic int exp_len(int a);
        int i   = a / REGION_STRIDE;
        int off = a % REGION_STRIDE;
        int l   = 2 + 2 * (i % 3);
        return (off < l) ? l - off : 0;
    endfunction

    function automatic int exp_wr(int a);
        return (exp_len(a) > 0) ? ((a / REGION_STRIDE) % 2) : 0;
    endfunction

    function automatic int bwritable();
        return (bwf != 0 && brem > 0) ? 1 : 0;
    endfunction

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    task automatic translate(int a);
        @(negedge clk); xlat_req = 1'b1; xlat_addr = ADDR_W'(a);
        @(negedge clk); xlat_req = 1'b0;
        chk("R2 done low after request", 32'(xlat_done), 0);
        repeat (XLAT_LAT - 1) @(negedge clk);
        chk("R2 still busy one cycle before latency", 32'(xlat_done), 0);
        @(negedge clk);
        chk("R2 done after latency", 32'(xlat_done), 1);
        nptr = a; nrem = exp_len(a); nwf = exp_wr(a);
    endtask

    task automatic do_commit();
        @(negedge clk); commit = 1'b1;
        @(negedge clk); commit = 1'b0;
        bptr = nptr; brem = nrem; bwf = nwf; berr = 0;
        chk("R3/R4 remaining length", 32'(remain_len), 32'(brem));
        chk("R3/R4 writable flag", 32'(writable), 32'(bwritable()));
        chk("R5 commit clears error", 32'(wr_err), 0);
    endtask

    task automatic do_read(string rq);
        int exp;
        @(negedge clk); rd_strobe = 1'b1;
        @(negedge clk); rd_strobe = 1'b0;
        exp   = bpipe;
        bpipe = bmem[bptr];
        bptr  = (bptr + 1) % MEM_WORDS;
        if (brem > 0) brem--;
        chk(rq, 32'(rd_data), 32'(exp));
        chk("R7 remaining after read", 32'(remain_len), 32'(brem));
    endtask

    task automatic do_write(int v);
        @(negedge clk); wr_strobe = 1'b1; wr_data = DATA_W'(v);
        @(negedge clk); wr_strobe = 1'b0;
        if (bwritable() != 0) bmem[bptr] = v & ((1 << DATA_W) - 1);
        else berr = 1;
        bptr = (bptr + 1) % MEM_WORDS;
        if (brem > 0) brem--;
        chk("R8/R9 error flag after write", 32'(wr_err), 32'(berr));
        chk("R7 remaining after write", 32'(remain_len), 32'(brem));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        for (int a = 0; a < MEM_WORDS; a++) bmem[a] = (a * 37 + 5) & ((1 << DATA_W) - 1);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 done at reset", 32'(xlat_done), 1);
        chk("R1 length at reset", 32'(remain_len), 0);
        chk("R1 writable at reset", 32'(writable), 0);
        chk("R1 error at reset", 32'(wr_err), 0);
        chk("R1 data at reset", 32'(rd_data), 0);

        // sweep: every address, write once, read back through the pipeline
        for (int a = 0; a < MEM_WORDS; a++) begin
            translate(a);
            do_commit();
            do_write(a * 113 + 4660);
            translate(a);
            do_commit();
            do_read("R6 discard read returns stale pipeline");
            do_read("R6/R8 second read returns addressed word");
        end

        // R9: exhaust a 4-word writable region
        translate(8);
        do_commit();
        for (int k = 0; k < 4; k++) do_write(1000 + k);
        chk("R9 no error while in region", 32'(wr_err), 0);
        do_write(2222);
        chk("R9 error after length used up", 32'(wr_err), 1);
        translate(12);
        do_commit();
        do_read("R6 discard read");
        do_read("R9 dropped write left word 12 unchanged");

        // R7: pointer wrap from 63 to 0
        translate(63);
        do_commit();
        do_read("R6 discard read before wrap");
        do_read("R7 word 63");
        do_read("R7 wrapped to word 0");

        // R5/R2: commit and request while busy are ignored
        translate(9);
        do_commit();
        @(negedge clk); xlat_req = 1'b1; xlat_addr = ADDR_W'(16);
        @(negedge clk); xlat_req = 1'b1; xlat_addr = ADDR_W'(1); commit = 1'b1;
        @(negedge clk); xlat_req = 1'b0; commit = 1'b0;
        chk("R5 commit while busy ignored", 32'(remain_len), 32'(exp_len(9)));
        repeat (XLAT_LAT) @(negedge clk);
        chk("R2 done after busy sequence", 32'(xlat_done), 1);
        nptr = 16; nrem = exp_len(16); nwf = exp_wr(16);
        do_commit();
        chk("R2 request while busy ignored", 32'(remain_len), 6);
        do_read("R6 discard read after busy sequence");
        do_read("R6 word 16");

        summary();
        $finish;
    end

endmodule